// File: doc/BRIEF.md
# Palette Entry Converter

This block takes the raw palette words that a DMA engine fetches from memory and turns each one into a uniform palette entry. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue channel plus one transparency flag. The block hands the entries to a palette RAM through an index, a data bus and a write strobe. A single done pulse follows the last entry.

A conversion begins with a start pulse. The start pulse samples the pixel depth code, the two-bit palette word format and the monochrome flag. The pixel depth sets the number of entries: 4 for 2 bpp, 16 for 4 bpp and 256 for 8 bpp. Source words then arrive on a ready/valid stream, one entry for each accepted word. The formats differ in word width, bit positions and whether a transparency bit exists. In monochrome (grey) mode, the low byte of the word goes to all three channels.

The palette must be rebuilt whenever the format selection changes. Once a run has been started, a change on the format input restarts the conversion from entry 0 under the new format.

Top module: `pal_cvt`

## Requirements
- R1: The depth code on `depth_i` at a start pulse selects the entry count: code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. A start with any other code makes no write and no done pulse, and `in_ready_o` stays low.
- R2: Format code 0 reads a 16-bit word in 5:6:5 layout from bits 15:0. Red comes from bits 15:11, green from 10:5 and blue from 4:0. Each channel sits at the top of its byte, the low bits are zero, and the transparency flag is 0.
- R3: Format code 1 reads a 32-bit word. Red comes from bits 23:19, green from 15:10 and blue from 7:3, each at the top of its byte with zero fill. The transparency flag is bit 24.
- R4: Format code 2 reads a 32-bit word. Red comes from bits 23:18, green from 15:10 and blue from 7:2, each at the top of its byte with zero fill. The transparency flag is bit 24.
- R5: Format code 3 reads a 32-bit word. Red is bits 23:16, green is 15:8 and blue is 7:0. The transparency flag is bit 24.
- R6: When the monochrome flag was set at start, all three channels equal bits 7:0 of the word. The transparency flag still follows the format: 0 for format 0, bit 24 otherwise.
- R7: Words are accepted when `in_valid_i` and `in_ready_o` are both high at a clock edge. Each accepted word produces one write, with `wr_en_o` high in the cycle after acceptance. Indices run from 0 upward by one and cover the whole entry count.
- R8: `done_o` is high for exactly one cycle, the cycle after the write of the last entry. `in_ready_o` is low once the last word has been accepted.
- R9: After a start with a supported depth, a new value on `fmt_i` restarts the conversion at index 0 under the new format. `in_ready_o` is low in the cycle the new value appears, so the word offered in that cycle is not taken.
- R10: While reset is held and just after it is released, `in_ready_o`, `wr_en_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion run; samples depth, format and grey flag |
| depth_i | input | 4 | Pixel depth code (1, 2, 3 supported) |
| fmt_i | input | 2 | Palette word format code |
| mono_i | input | 1 | Grey mode flag |
| in_valid_i | input | 1 | Source word valid |
| in_ready_o | output | 1 | Block accepts a source word |
| in_word_i | input | 32 | Source palette word (format 0 uses bits 15:0) |
| wr_en_o | output | 1 | Palette RAM write strobe |
| wr_idx_o | output | 8 | Palette entry index |
| wr_rgb_o | output | 24 | Converted colour, red in 23:16, green 15:8, blue 7:0 |
| wr_trans_o | output | 1 | Converted transparency flag |
| done_o | output | 1 | One-cycle pulse after the last entry write |

## Verification
The hardest case to reach from the ports is a format change partway through a run. The change has to land in exactly the cycle that a word is being offered. The bench feeds several words under one format, then changes `fmt_i` in the same cycle it presents a word that must be refused. It checks that ready drops in that cycle, and that the writes which follow start again at index 0 and carry the new format's conversion of the later words. A full 256-entry run with valid gaps also exercises the last index and the done timing at the largest count.

// File: rtl/pal_cvt_pkg.sv
package pal_cvt_pkg;
  localparam int MAX_ENTRIES = 256;
  localparam int IDX_W       = $clog2(MAX_ENTRIES);
  localparam int CNT_W       = IDX_W + 1;
  localparam int WORD_W      = 32;
  localparam int DEPTH_W     = 4;

  typedef enum logic [1:0] {
    FMT_565   = 2'd0,
    FMT_565T  = 2'd1,
    FMT_666T  = 2'd2,
    FMT_888T  = 2'd3
  } pal_fmt_e;

  localparam logic [DEPTH_W-1:0] DEPTH_2B = 4'd1;
  localparam logic [DEPTH_W-1:0] DEPTH_4B = 4'd2;
  localparam logic [DEPTH_W-1:0] DEPTH_8B = 4'd3;

  typedef struct packed {
    logic       trans;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pal_entry_t;

  // zero means no conversion for this depth
  function automatic logic [CNT_W-1:0] entries_for(input logic [DEPTH_W-1:0] d);
    case (d)
      DEPTH_2B: entries_for = CNT_W'(4);
      DEPTH_4B: entries_for = CNT_W'(16);
      DEPTH_8B: entries_for = CNT_W'(256);
      default:  entries_for = '0;
    endcase
  endfunction
endpackage

// File: rtl/pal_cvt_decode.sv
module pal_cvt_decode
  import pal_cvt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  pal_fmt_e          fmt_i,
  input  logic              mono_i,
  output pal_entry_t        entry_o
);
  logic [7:0] r, g, b;
  logic       t;

  always_comb begin
    case (fmt_i)
      FMT_565: begin
        r = {word_i[15:11], 3'b000};
        g = {word_i[10:5],  2'b00};
        b = {word_i[4:0],   3'b000};
        t = 1'b0;
      end
      FMT_565T: begin
        r = {word_i[23:19], 3'b000};
        g = {word_i[15:10], 2'b00};
        b = {word_i[7:3],   3'b000};
        t = word_i[24];
      end
      FMT_666T: begin
        r = {word_i[23:18], 2'b00};
        g = {word_i[15:10], 2'b00};
        b = {word_i[7:2],   2'b00};
        t = word_i[24];
      end
      default: begin
        r = word_i[23:16];
        g = word_i[15:8];
        b = word_i[7:0];
        t = word_i[24];
      end
    endcase
    entry_o.trans = t;
    if (mono_i) begin
      entry_o.r = word_i[7:0];
      entry_o.g = word_i[7:0];
      entry_o.b = word_i[7:0];
    end else begin
      entry_o.r = r;
      entry_o.g = g;
      entry_o.b = b;
    end
  end
endmodule

// File: rtl/pal_cvt_seq.sv
module pal_cvt_seq
  import pal_cvt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [1:0]         fmt_i,
  input  logic               mono_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  output logic               acc_o,
  output logic [IDX_W-1:0]   acc_idx_o,
  output logic               acc_last_o,
  output logic [CNT_W-1:0]   cnt_o,
  output pal_fmt_e           fmt_o,
  output logic               mono_o
);
  logic               busy_q, armed_q, mono_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   cnt_q;
  pal_fmt_e           fmt_q;
  logic [CNT_W-1:0]   start_cnt;
  logic               start_ok, restart, last;

  assign start_cnt  = entries_for(depth_i);
  assign start_ok   = start_i && (start_cnt != '0);
  assign restart    = armed_q && !start_i && (fmt_i != fmt_q);
  assign in_ready_o = busy_q && !start_i && !restart;
  assign acc_o      = in_ready_o && in_valid_i;
  assign last       = ({1'b0, idx_q} == (cnt_q - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      mono_q  <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      fmt_q   <= FMT_565;
    end else if (start_i) begin
      busy_q  <= start_ok;
      armed_q <= start_ok;
      idx_q   <= '0;
      if (start_ok) begin
        cnt_q  <= start_cnt;
        fmt_q  <= pal_fmt_e'(fmt_i);
        mono_q <= mono_i;
      end
    end else if (restart) begin
      // new format invalidates every entry written so far
      busy_q <= 1'b1;
      idx_q  <= '0;
      fmt_q  <= pal_fmt_e'(fmt_i);
    end else if (acc_o) begin
      idx_q <= idx_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  assign acc_idx_o  = idx_q;
  assign acc_last_o = last;
  assign cnt_o      = cnt_q;
  assign fmt_o      = fmt_q;
  assign mono_o     = mono_q;

  assert_bad_depth_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !start_ok) |=> !in_ready_o);

  assert_ascending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && !acc_last_o) |=> (acc_idx_o == $past(acc_idx_o) + 1'b1));

  assert_ready_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && acc_last_o && !$changed(fmt_i)) |=> (!in_ready_o || start_i || restart));

  assert_restart_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (acc_idx_o == '0 && in_ready_o == (!start_i && fmt_i == fmt_o)));
endmodule

// File: rtl/pal_cvt.sv
module pal_cvt
  import pal_cvt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [1:0]         fmt_i,
  input  logic               mono_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [WORD_W-1:0]  in_word_i,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [23:0]        wr_rgb_o,
  output logic               wr_trans_o,
  output logic               done_o
);
  logic             acc, acc_last, mono_q;
  logic [IDX_W-1:0] acc_idx;
  logic [CNT_W-1:0] cnt;
  pal_fmt_e         fmt_q;
  pal_entry_t       entry;

  logic             wr_en_q, wr_last_q, done_q, wr_trans_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [23:0]      wr_rgb_q;

  pal_cvt_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .depth_i    (depth_i),
    .fmt_i      (fmt_i),
    .mono_i     (mono_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .acc_o      (acc),
    .acc_idx_o  (acc_idx),
    .acc_last_o (acc_last),
    .cnt_o      (cnt),
    .fmt_o      (fmt_q),
    .mono_o     (mono_q)
  );

  pal_cvt_decode u_dec (
    .word_i  (in_word_i),
    .fmt_i   (fmt_q),
    .mono_i  (mono_q),
    .entry_o (entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q    <= 1'b0;
      wr_last_q  <= 1'b0;
      done_q     <= 1'b0;
      wr_idx_q   <= '0;
      wr_rgb_q   <= '0;
      wr_trans_q <= 1'b0;
    end else begin
      wr_en_q   <= acc;
      wr_last_q <= acc && acc_last;
      done_q    <= wr_last_q;
      if (acc) begin
        wr_idx_q   <= acc_idx;
        wr_rgb_q   <= {entry.r, entry.g, entry.b};
        wr_trans_q <= entry.trans;
      end
    end
  end

  assign wr_en_o    = wr_en_q;
  assign wr_idx_o   = wr_idx_q;
  assign wr_rgb_o   = wr_rgb_q;
  assign wr_trans_o = wr_trans_q;
  assign done_o     = done_q;

  assert_fmt0_opaque_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && fmt_q == FMT_565) |=> !wr_trans_o);

  assert_grey_equal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && mono_q) |=> (wr_rgb_o[23:16] == wr_rgb_o[15:8] && wr_rgb_o[15:8] == wr_rgb_o[7:0]));

  assert_idx_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> ({1'b0, wr_idx_o} < $past(cnt)));

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_last_q) |=> done_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_pal_cvt.sv
module sim_pal_cvt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  depth_i = '0;
  logic [1:0]  fmt_i = '0;
  logic        mono_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_word_i = '0;
  logic        wr_en_o;
  logic [7:0]  wr_idx_o;
  logic [23:0] wr_rgb_o;
  logic        wr_trans_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  pal_cvt u0 (.*);

  // write log, filled only here
  logic [7:0]  log_idx [0:599];
  logic [24:0] log_dat [0:599];
  int tot_log = 0;
  int tot_done = 0;

  always @(negedge clk_i) begin
    if (rst_ni && wr_en_o && tot_log < 600) begin
      log_idx[tot_log] = wr_idx_o;
      log_dat[tot_log] = {wr_trans_o, wr_rgb_o};
      tot_log = tot_log + 1;
    end
    if (rst_ni && done_o) tot_done = tot_done + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] model(input logic [1:0] f, input logic m, input logic [31:0] w);
    logic [7:0] r, g, b; logic t;
    case (f)
      2'd0: begin r = {w[15:11],3'b0}; g = {w[10:5],2'b0}; b = {w[4:0],3'b0}; t = 1'b0; end
      2'd1: begin r = {w[23:19],3'b0}; g = {w[15:10],2'b0}; b = {w[7:3],3'b0}; t = w[24]; end
      2'd2: begin r = {w[23:18],2'b0}; g = {w[15:10],2'b0}; b = {w[7:2],2'b0}; t = w[24]; end
      default: begin r = w[23:16]; g = w[15:8]; b = w[7:0]; t = w[24]; end
    endcase
    if (m) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
    return {t, r, g, b};
  endfunction

  function automatic logic [31:0] gen(input logic [31:0] seed, input logic [31:0] step, input int i);
    return seed + step * i;
  endfunction

  // run one conversion, check every write against the model
  task automatic run(input logic [3:0] d, input logic [1:0] f, input logic m, input int n,
                     input logic [31:0] seed, input logic [31:0] step, input bit stall, input string req);
    int base_l, base_d;
    base_l = tot_log; base_d = tot_done;
    @(negedge clk_i);
    start_i = 1'b1; depth_i = d; fmt_i = f; mono_i = m;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (stall && (i % 3 == 1)) begin
        in_valid_i = 1'b0;
        @(negedge clk_i);
      end
      in_valid_i = 1'b1;
      in_word_i = gen(seed, step, i);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    #1;
    chk(in_ready_o == 1'b0, "R8 ready low after last word", in_ready_o, 0);
    repeat (4) @(negedge clk_i);
    chk(tot_log - base_l == n, {req, " R7 write count"}, tot_log - base_l, n);
    chk(tot_done - base_d == 1, "R8 single done pulse", tot_done - base_d, 1);
    for (int k = 0; k < n && base_l + k < tot_log; k++) begin
      logic [24:0] e;
      e = model(f, m, gen(seed, step, k));
      chk(log_idx[base_l+k] == 8'(k) && log_dat[base_l+k] == e, {req, " R7 entry"},
          {log_idx[base_l+k], log_dat[base_l+k][23:0]}, {8'(k), e[23:0]});
    end
  endtask

  typedef struct packed {
    logic [1:0]  f;
    logic        m;
    logic [31:0] w;
    logic [24:0] exp;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{2'd0, 1'b0, 32'h0000F81F, 25'h0F800F8},  // R2
    '{2'd0, 1'b0, 32'hFFFF07E0, 25'h000FC00},  // R2 upper bits ignored
    '{2'd1, 1'b0, 32'h01FFFFFF, 25'h1F8FCF8},  // R3
    '{2'd1, 1'b0, 32'h00070307, 25'h0000000},  // R3 dropped low bits
    '{2'd2, 1'b0, 32'h01FCFCFC, 25'h1FCFCFC},  // R4
    '{2'd2, 1'b0, 32'h00030303, 25'h0000000},  // R4
    '{2'd3, 1'b0, 32'h01123456, 25'h1123456},  // R5
    '{2'd0, 1'b1, 32'h0000ABCD, 25'h0CDCDCD},  // R6 format 0 opaque
    '{2'd3, 1'b1, 32'h01AABB77, 25'h1777777},  // R6 trans follows
    '{2'd2, 1'b1, 32'h00000080, 25'h0808080}   // R6
  };

  initial begin
    repeat (3) @(negedge clk_i);
    chk(in_ready_o == 0 && wr_en_o == 0 && done_o == 0, "R10 reset outputs",
        {in_ready_o, wr_en_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 0 && wr_en_o == 0 && done_o == 0, "R10 after release",
        {in_ready_o, wr_en_o, done_o}, 0);

    // table walk: 2 bpp runs, same word four times
    for (int v = 0; v < 10; v++) begin
      int b;
      b = tot_log;
      run(4'd1, VECS[v].f, VECS[v].m, 4, VECS[v].w, 32'd0, 1'b0, "R1 table");
      chk(log_dat[b] == VECS[v].exp, "R2-6 table vector R3 R4 R5 R6 R2", log_dat[b], VECS[v].exp);
    end

    // 4 bpp, varied words, formats 0 and 1
    run(4'd2, 2'd0, 1'b0, 16, 32'h00A55A3C, 32'h01050B13, 1'b0, "R1 R2 depth 16");
    run(4'd2, 2'd1, 1'b0, 16, 32'h00C3F00F, 32'h00931D47, 1'b1, "R1 R3 depth 16");
    // 8 bpp full palette with valid gaps
    run(4'd3, 2'd2, 1'b0, 256, 32'h00123456, 32'h01070B0D, 1'b1, "R1 R4 depth 256");

    // unsupported depth codes
    foreach (VECS[v]) if (v < 2) begin
      int bl, bd;
      bl = tot_log; bd = tot_done;
      @(negedge clk_i);
      start_i = 1'b1; depth_i = (v == 0) ? 4'd0 : 4'd4; fmt_i = 2'd3;
      @(negedge clk_i);
      start_i = 1'b0;
      in_valid_i = 1'b1; in_word_i = 32'h01FFFFFF;
      #1;
      chk(in_ready_o == 0, "R1 bad depth ready", in_ready_o, 0);
      repeat (6) @(negedge clk_i);
      in_valid_i = 1'b0;
      chk(tot_log == bl && tot_done == bd, "R1 bad depth no write", tot_log - bl, 0);
    end

    // format change mid-run restarts at index 0
    begin
      int bl, bd;
      bl = tot_log; bd = tot_done;
      @(negedge clk_i);
      start_i = 1'b1; depth_i = 4'd2; fmt_i = 2'd3; mono_i = 1'b0;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int i = 0; i < 5; i++) begin
        in_valid_i = 1'b1; in_word_i = 32'h00100000 + 32'(i);
        @(negedge clk_i);
      end
      fmt_i = 2'd1; in_word_i = 32'hDEADBEEF;
      #1;
      chk(in_ready_o == 0, "R9 ready low on change", in_ready_o, 0);
      @(negedge clk_i);
      for (int i = 0; i < 16; i++) begin
        in_valid_i = 1'b1; in_word_i = 32'h01F8FCF8 - 32'(i * 32'h00081008);
        @(negedge clk_i);
      end
      in_valid_i = 1'b0;
      repeat (4) @(negedge clk_i);
      chk(tot_log - bl == 21, "R9 write count", tot_log - bl, 21);
      chk(tot_done - bd == 1, "R9 one done", tot_done - bd, 1);
      for (int k = 0; k < 5; k++)
        chk(log_idx[bl+k] == 8'(k) && log_dat[bl+k] == model(2'd3, 1'b0, 32'h00100000 + 32'(k)),
            "R9 before change", log_idx[bl+k], k);
      for (int k = 0; k < 16; k++) begin
        logic [24:0] e;
        e = model(2'd1, 1'b0, 32'h01F8FCF8 - 32'(k * 32'h00081008));
        chk(log_idx[bl+5+k] == 8'(k) && log_dat[bl+5+k] == e, "R9 after restart",
            {log_idx[bl+5+k], log_dat[bl+5+k][23:0]}, {8'(k), e[23:0]});
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule